// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating converter with a 4-1/2 digit result. It steps a fixed-period conversion cycle through four phases: auto-zero, signal integrate, reference integrate and integrator zero. It raises one phase-enable line at a time for the analog front end. Signal integrate has a fixed length. Reference integrate is counted in decimal until the external comparator reports that the integrator has crossed zero.

The stopped count is loaded into a BCD result register. The top digit of that register is 0 or 1, so a full-scale input of twice the reference reads 1.9999. The sign of the integrator at the start of reference integrate is latched as the input polarity. A reading that does not finish in time is flagged as overrange. A one-clock strobe marks each new result.

The comparator input is high while the integrator output lies on the side produced by a positive input. Any time left in the cycle after reference integrate is spent in integrator zero, so every conversion has the same period.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is low, and until the second rising clock edge after it is released, the block sits at the start of the cycle in auto-zero. The polarity, result, overrange and strobe outputs are all 0 in that state. Asserting reset at any point mid-cycle returns the block to this state at once.
- R2: Each cycle lasts exactly CYCLE_CLKS clocks and runs as follows: AZ_CLKS clocks of auto-zero, then exactly 10^NDIG clocks of signal integrate (10,000 by default), then reference integrate, then integrator zero until the cycle ends. Cycle length does not depend on the reading.
- R3: Exactly one of the four phase-enable outputs is high in every clock.
- R4: Polarity is taken from the comparator at the clock edge that starts reference integrate, where 1 means a positive input. It is held until the same edge of the next cycle, including when the reading is zero.
- R5: Reference integrate ends on the first clock in which the comparator differs from the latched polarity. The result then equals the number of reference-integrate clocks before that clock. It is coded in BCD, with digit i in bits [4i+3:4i] and the top digit 0 or 1, giving a range of 0 to 2*10^NDIG-1.
- R6: If no crossing occurs within 2*10^NDIG reference-integrate clocks, reference integrate ends after exactly that many clocks. The overrange output is then set and the result is all zeros. A normal reading clears the overrange output.
- R7: data_rdy is high for exactly one clock per completed reading. That clock is the first one in which the new result, overrange and polarity values are visible.
- R8: The comparator has no effect in auto-zero, in integrator zero, or in signal integrate except at the edge that starts reference integrate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_pos | input | 1 | Comparator: integrator on the positive-input side |
| ph_az | output | 1 | Auto-zero phase enable |
| ph_si | output | 1 | Signal-integrate phase enable |
| ph_ri | output | 1 | Reference-integrate phase enable |
| ph_iz | output | 1 | Integrator-zero phase enable |
| polarity | output | 1 | Latched input sign, 1 = positive |
| result_bcd | output | 4*NDIG+4 | BCD reading, top digit 0 or 1 |
| over_range | output | 1 | Last reading exceeded full scale |
| data_rdy | output | 1 | One-clock strobe for a new reading |

## Verification
The bench builds the block with NDIG=2, AZ_CLKS=20 and CYCLE_CLKS=400, which gives a 100-clock signal integrate and a 200-count full scale. At these values a full cycle takes 400 clocks, so zero readings of both signs, the reading equal to the reference (100), the largest in-range reading (199), an overrange and a mid-conversion reset all fit into about ten cycles. The digit carries and the top-digit limit behave the same as at the default size.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    PH_AZ = 2'd0,
    PH_SI = 2'd1,
    PH_RI = 2'd2,
    PH_IZ = 2'd3
  } phase_e;

  function automatic int pow10(input int n);
    int r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction
endpackage

// File: rtl/dsc_cycle_timer.sv
module dsc_cycle_timer #(
  parameter int CYCLE_CLKS = 40000,
  parameter int AZ_CLKS    = 4000,
  parameter int SIG_CLKS   = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic az_last,
  output logic si_last,
  output logic cyc_last
);
  localparam int TW = $clog2(CYCLE_CLKS);

  logic [TW-1:0] t_q, t_d;

  assign az_last  = (t_q == TW'(AZ_CLKS - 1));
  assign si_last  = (t_q == TW'(AZ_CLKS + SIG_CLKS - 1));
  assign cyc_last = (t_q == TW'(CYCLE_CLKS - 1));

  always_comb begin
    t_d = t_q + 1'b1;
    if (cyc_last) t_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= '0;
    else        t_q <= t_d;
  end

  // R2
  cycle_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_last) |-> az_last == (AZ_CLKS == 1));
endmodule

// File: rtl/dsc_bcd_counter.sv
module dsc_bcd_counter #(
  parameter int NDIG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            inc,
  output logic [4*NDIG-1:0] low_q,
  output logic            top_q,
  output logic            at_max
);
  logic [NDIG:0]   cy;
  logic [NDIG-1:0] nine;
  logic            top_d;

  assign cy[0] = inc;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [3:0] q, d;

    always_comb begin
      d = q;
      if (clr)        d = 4'd0;
      else if (cy[g]) d = (q == 4'd9) ? 4'd0 : q + 4'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 4'd0;
      else        q <= d;
    end

    assign cy[g+1]        = cy[g] & (q == 4'd9);
    assign nine[g]        = (q == 4'd9);
    assign low_q[4*g +: 4] = q;

    // R5
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q <= 4'd9);
  end

  always_comb begin
    top_d = top_q;
    if (clr)           top_d = 1'b0;
    else if (cy[NDIG]) top_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) top_q <= 1'b0;
    else        top_q <= top_d;
  end

  assign at_max = top_q & (&nine);

  // R5
  top_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_q && !clr) |=> top_q);
endmodule

// File: rtl/dsc_phase_fsm.sv
module dsc_phase_fsm
  import dsc_pkg::*;
#(
  parameter int NDIG     = 4,
  parameter int SIG_CLKS = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              az_last,
  input  logic              si_last,
  input  logic              cyc_last,
  input  logic              cmp_pos,
  input  logic [4*NDIG-1:0] cnt_low,
  input  logic              cnt_top,
  input  logic              cnt_max,
  output logic              cnt_clr,
  output logic              cnt_inc,
  output phase_e            ph_q,
  output logic              pol_q,
  output logic [4*NDIG+3:0] res_q,
  output logic              ovr_q,
  output logic              rdy_q
);
  localparam int SW = $clog2(SIG_CLKS + 1);

  phase_e            ph_d;
  logic              pol_d, ovr_d, rdy_d, crossing;
  logic [4*NDIG+3:0] res_d;

  assign crossing = (cmp_pos != pol_q);

  always_comb begin
    ph_d    = ph_q;
    pol_d   = pol_q;
    res_d   = res_q;
    ovr_d   = ovr_q;
    rdy_d   = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    case (ph_q)
      PH_AZ: if (az_last) ph_d = PH_SI;
      PH_SI: if (si_last) begin
        ph_d    = PH_RI;
        pol_d   = cmp_pos;
        cnt_clr = 1'b1;
      end
      PH_RI: begin
        if (crossing) begin
          ph_d  = PH_IZ;
          res_d = {3'b000, cnt_top, cnt_low};
          ovr_d = 1'b0;
          rdy_d = 1'b1;
        end else if (cnt_max) begin
          ph_d  = PH_IZ;
          res_d = '0;
          ovr_d = 1'b1;
          rdy_d = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      PH_IZ: if (cyc_last) ph_d = PH_AZ;
      default: ph_d = PH_AZ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_AZ;
      pol_q <= 1'b0;
      res_q <= '0;
      ovr_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      pol_q <= pol_d;
      res_q <= res_d;
      ovr_q <= ovr_d;
      rdy_q <= rdy_d;
    end
  end

  // Signal-integrate length monitor for the checks below.
  logic [SW-1:0] si_len_q, si_len_d;
  always_comb si_len_d = (ph_q == PH_SI) ? si_len_q + 1'b1 : '0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) si_len_q <= '0;
    else        si_len_q <= si_len_d;
  end

  // R2
  si_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SI && ph_d != PH_SI) |-> si_len_q == SW'(SIG_CLKS - 1));
  // R4
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_q == PH_SI && ph_d == PH_RI) |=> $stable(pol_q));
  // R6
  ovr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && ovr_q) |-> res_q == '0);
  // R7
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> !rdy_q);
  // R7
  rdy_enters_iz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> ph_q == PH_IZ);
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int NDIG       = 4,
  parameter int CYCLE_CLKS = 40000,
  parameter int AZ_CLKS    = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_pos,
  output logic              ph_az,
  output logic              ph_si,
  output logic              ph_ri,
  output logic              ph_iz,
  output logic              polarity,
  output logic [4*NDIG+3:0] result_bcd,
  output logic              over_range,
  output logic              data_rdy
);
  localparam int SIG_CLKS = pow10(NDIG);

  logic [1:0] rs_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int = rs_q[1];

  logic              az_last, si_last, cyc_last;
  logic              cnt_clr, cnt_inc, cnt_top, cnt_max;
  logic [4*NDIG-1:0] cnt_low;
  phase_e            ph_q;

  dsc_cycle_timer #(
    .CYCLE_CLKS(CYCLE_CLKS), .AZ_CLKS(AZ_CLKS), .SIG_CLKS(SIG_CLKS)
  ) u_timer (
    .clk(clk), .rst_n(rst_int),
    .az_last(az_last), .si_last(si_last), .cyc_last(cyc_last)
  );

  dsc_bcd_counter #(.NDIG(NDIG)) u_count (
    .clk(clk), .rst_n(rst_int), .clr(cnt_clr), .inc(cnt_inc),
    .low_q(cnt_low), .top_q(cnt_top), .at_max(cnt_max)
  );

  dsc_phase_fsm #(.NDIG(NDIG), .SIG_CLKS(SIG_CLKS)) u_fsm (
    .clk(clk), .rst_n(rst_int),
    .az_last(az_last), .si_last(si_last), .cyc_last(cyc_last),
    .cmp_pos(cmp_pos),
    .cnt_low(cnt_low), .cnt_top(cnt_top), .cnt_max(cnt_max),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .ph_q(ph_q), .pol_q(polarity), .res_q(result_bcd),
    .ovr_q(over_range), .rdy_q(data_rdy)
  );

  assign ph_az = (ph_q == PH_AZ);
  assign ph_si = (ph_q == PH_SI);
  assign ph_ri = (ph_q == PH_RI);
  assign ph_iz = (ph_q == PH_IZ);

  // R3
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_int)
    $onehot({ph_az, ph_si, ph_ri, ph_iz}));
  // R2
  iz_to_az_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (ph_iz && cyc_last) |=> ph_az);
endmodule

// File: tb/sim_dual_slope_seq.sv
module sim_dual_slope_seq;
  localparam int NDIG = 2;
  localparam int AZ   = 20;
  localparam int CYC  = 400;
  localparam int SIG  = 100;
  localparam int FULL = 200;
  localparam int RW   = 4*NDIG + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp = 1'b0;
  logic          ph_az, ph_si, ph_ri, ph_iz, polarity, over_range, data_rdy;
  logic [RW-1:0] result_bcd;

  dual_slope_seq #(.NDIG(NDIG), .CYCLE_CLKS(CYC), .AZ_CLKS(AZ)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_pos(cmp),
    .ph_az(ph_az), .ph_si(ph_si), .ph_ri(ph_ri), .ph_iz(ph_iz),
    .polarity(polarity), .result_bcd(result_bcd),
    .over_range(over_range), .data_rdy(data_rdy)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit timeout = 0;

  // Per-cycle stimulus: sign of input and RI clock of crossing (-1 = never).
  int p_sp[8] = '{1, 0, 1, 0, 1, 0, 1, 1};
  int p_kc[8] = '{37, 0, 199, -1, 100, 5, 0, 150};

  // Behavioural reference model.
  int m_t = 0, m_ph = 0, m_cnt = 0, m_res = 0, rel = 0, pidx = 0;
  bit m_pol = 0, m_ovr = 0, m_rdy = 0;

  function automatic logic [RW-1:0] to_bcd(input int v);
    logic [RW-1:0] r;
    int x;
    r = '0;
    x = v;
    for (int i = 0; i < NDIG + 1; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic ceq(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (t=%0d pat=%0d)", req, act, exp, m_t, pidx);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) rel = 0;
    else if (rel < 3) rel++;
    if (rel <= 2) begin
      m_t = 0; m_ph = 0; m_cnt = 0; m_res = 0;
      m_pol = 0; m_ovr = 0; m_rdy = 0;
    end else begin
      m_rdy = 0;
      case (m_ph)
        0: if (m_t == AZ - 1) m_ph = 1;
        1: if (m_t == AZ + SIG - 1) begin m_ph = 2; m_pol = cmp; m_cnt = 0; end
        2: begin
          if (cmp != m_pol) begin
            m_res = m_cnt; m_ovr = 0; m_rdy = 1; m_ph = 3;
          end else if (m_cnt == FULL - 1) begin
            m_res = 0; m_ovr = 1; m_rdy = 1; m_ph = 3;
          end else m_cnt++;
        end
        default: if (m_t == CYC - 1) m_ph = 0;
      endcase
      if (m_t == CYC - 1) begin m_t = 0; pidx++; end
      else m_t++;
    end
  end

  task automatic check_reset_state(input string tag);
    ceq({tag, " R1 ph_az"}, 32'(ph_az), 1);
    ceq({tag, " R1 other phases"}, 32'({ph_si, ph_ri, ph_iz}), 0);
    ceq({tag, " R1 polarity"}, 32'(polarity), 0);
    ceq({tag, " R1 result"}, 32'(result_bcd), 0);
    ceq({tag, " R1 overrange/strobe"}, 32'({over_range, data_rdy}), 0);
  endtask

  task automatic compare_all();
    ceq("R3 one phase", 32'($countones({ph_az, ph_si, ph_ri, ph_iz})), 1);
    ceq("R2 phase az", 32'(ph_az), 32'(m_ph == 0));
    ceq("R2 phase si", 32'(ph_si), 32'(m_ph == 1));
    ceq("R2 R5 phase ri", 32'(ph_ri), 32'(m_ph == 2));
    ceq("R2 phase iz", 32'(ph_iz), 32'(m_ph == 3));
    ceq("R4 polarity", 32'(polarity), 32'(m_pol));
    ceq("R5 R8 result", 32'(result_bcd), 32'(to_bcd(m_res)));
    ceq("R6 overrange", 32'(over_range), 32'(m_ovr));
    ceq("R7 strobe", 32'(data_rdy), 32'(m_rdy));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    timeout = 1;
  end

  initial begin
    bit did_rst;
    int sp, kc;
    did_rst = 0;
    repeat (3) @(negedge clk);
    check_reset_state("initial");
    rst_n = 1'b1;
    while (pidx < 10 && !timeout) begin
      @(negedge clk);
      compare_all();
      sp = p_sp[pidx % 8];
      kc = p_kc[pidx % 8];
      if (!did_rst && pidx == 7 && m_ph == 2 && m_cnt == 60) begin
        did_rst = 1;
        rst_n = 1'b0;
        #1;
        check_reset_state("mid-cycle");
        @(negedge clk);
        rst_n = 1'b1;
        pidx++;
        continue;
      end
      // R8: comparator randomised wherever it must have no effect.
      case (m_ph)
        1: cmp = (m_t == AZ + SIG - 1) ? sp[0] : 1'($urandom % 2);
        2: cmp = (kc >= 0 && m_cnt >= kc) ? ~sp[0] : sp[0];
        default: cmp = 1'($urandom % 2);
      endcase
    end
    if (timeout) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", pidx, 10);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule